// File: doc/BRIEF.md
# Per-line serial parameter register

This block holds the line settings of a four-line serial multiplexer. Software reaches it through one shared 16-bit write port. Each written word carries the number of the target line in its lowest bits. The rest of the same word gives that line's complete setting: data bits per character, stop bits, parity enable and sense, a rate code and a receiver enable. Each line keeps its own stored copy of these settings and drives them to the serializer attached to that line. The register cannot be read back.

Every line also has its own bit-rate tick generator, clocked from the shared block clock. The rate code selects one of fifteen fixed rates from 50 to 9600 bits per second. The divisor for each rate is computed at elaboration from the clock frequency. A write to a line reloads that line's counter, so a new rate starts on a clean period.

Top module: `line_param_reg`

## Requirements
- R1: A write (`wr_en` high at a rising clock edge) updates only the line whose number is in `wr_data[1:0]`. Every other line, and every line while `wr_en` is low, keeps its settings and its tick phase.
- R2: `wr_data[4:3]` sets the data bits per character. Code 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. The value appears on the line's 4-bit slice of `data_bits` after the capturing edge.
- R3: `wr_data[5]` selects two stop bits, `wr_data[6]` enables parity, and `wr_data[7]` selects odd parity instead of even. Each drives the matching per-line output.
- R4: `wr_data[11:8]` is the rate code. Codes 0 to 14 select, in order, 50, 75, 110, 134, 150, 300, 600, 1200, 1800, 2000, 2400, 3600, 4800, 7200 and 9600 bits per second. The line's tick is then high for one cycle every DIV cycles, where DIV = (CLK_HZ + rate/2) / rate.
- R5: `wr_data[12]` sets the line's receiver enable. A later write to that line with the bit cleared drops `rx_en` for that line.
- R6: Rate code 15 selects 9600 bits per second.
- R7: After a write to a line, that line's tick is first high DIV-1 rising edges after the capturing edge. It then repeats every DIV cycles.
- R8: After reset, every line has its receiver disabled, 8 data bits, one stop bit, parity off, and the 9600 bits per second rate.
- R9: Bit 2 and bits 15:13 of the written word have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the parameter word |
| wr_data | input | 16 | Parameter word: line number and settings |
| rx_en | output | NUM_LINES | Receiver enable per line |
| data_bits | output | 4*NUM_LINES | Data bits per character, 4 bits per line |
| two_stop | output | NUM_LINES | Two stop bits per line |
| par_en | output | NUM_LINES | Parity enable per line |
| par_odd | output | NUM_LINES | Odd parity per line |
| bit_tick | output | NUM_LINES | One-cycle bit-rate tick per line |

## Verification
The bench builds the block with four lines and CLK_HZ set to 96000. With that clock, the divisors run from 10 at 9600 bits per second up to 1920 at 50 bits per second. Every rate code, including the fallback code 15, can then be timed to the exact cycle, both the first tick after a reload and the full period. The rounding of the non-integer rates, such as 134 and 7200, is checked as well. Random words with the unused bits set check that each line is decoded and held apart from the others.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

  // Field positions inside the written parameter word
  localparam int SIZE_LSB = 3;
  localparam int STOP_BIT = 5;
  localparam int PEN_BIT  = 6;
  localparam int ODD_BIT  = 7;
  localparam int RATE_LSB = 8;
  localparam int RX_BIT   = 12;

  localparam logic [3:0] RATE_DEFAULT = 4'd14;

  typedef struct packed {
    logic       rx_en;
    logic       par_odd;
    logic       par_en;
    logic       two_stop;
    logic [1:0] size;
    logic [3:0] rate;
  } line_cfg_t;

  localparam line_cfg_t CFG_RESET = '{rx_en: 1'b0, par_odd: 1'b0, par_en: 1'b0,
                                      two_stop: 1'b0, size: 2'd3, rate: RATE_DEFAULT};

  function automatic int unsigned lpr_bps(input logic [3:0] code);
    case (code)
      4'd0:    return 50;
      4'd1:    return 75;
      4'd2:    return 110;
      4'd3:    return 134;
      4'd4:    return 150;
      4'd5:    return 300;
      4'd6:    return 600;
      4'd7:    return 1200;
      4'd8:    return 1800;
      4'd9:    return 2000;
      4'd10:   return 2400;
      4'd11:   return 3600;
      4'd12:   return 4800;
      4'd13:   return 7200;
      default: return 9600;
    endcase
  endfunction

  function automatic int unsigned lpr_div(input int unsigned clk_hz, input logic [3:0] code);
    int unsigned bps;
    bps = lpr_bps(code);
    return (clk_hz + bps / 2) / bps;
  endfunction

endpackage

// File: rtl/lpr_decode.sv
module lpr_decode
  import lpr_pkg::*;
#(
  parameter int LINE_W = 2
) (
  input  logic [15:0]       word,
  output logic [LINE_W-1:0] line_idx,
  output line_cfg_t         cfg
);

  always_comb begin
    line_idx     = word[LINE_W-1:0];
    cfg.rx_en    = word[RX_BIT];
    cfg.par_odd  = word[ODD_BIT];
    cfg.par_en   = word[PEN_BIT];
    cfg.two_stop = word[STOP_BIT];
    cfg.size     = word[SIZE_LSB +: 2];
    cfg.rate     = word[RATE_LSB +: 4];
  end

endmodule

// File: rtl/lpr_line_store.sv
module lpr_line_store
  import lpr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  line_cfg_t cfg_in,
  output line_cfg_t cfg_q
);

  line_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (load) cfg_d = cfg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

  // R1: an unaddressed line keeps its settings
  assert_hold_unaddressed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_q));

  // R5: the receiver enable follows the written bit
  assert_rx_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cfg_q.rx_en == $past(cfg_in.rx_en));

endmodule

// File: rtl/lpr_tick_gen.sv
module lpr_tick_gen
  import lpr_pkg::*;
#(
  parameter int unsigned CLK_HZ = 1843200,
  parameter int          CNT_W  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [3:0] rate_code,
  output logic       tick
);

  localparam logic [CNT_W-1:0] DEF_DIV = CNT_W'(lpr_div(CLK_HZ, RATE_DEFAULT));

  logic [CNT_W-1:0] div_q, div_d, cnt_q, cnt_d, div_new;

  assign div_new = CNT_W'(lpr_div(CLK_HZ, rate_code));
  assign tick    = (cnt_q == '0);

  always_comb begin
    div_d = div_q;
    cnt_d = cnt_q - 1'b1;
    if (load) begin
      div_d = div_new;
      cnt_d = div_new - 1'b1;
    end else if (tick) begin
      cnt_d = div_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DEF_DIV;
      cnt_q <= DEF_DIV - 1'b1;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  // R4: a tick lasts one cycle, never two in a row
  assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R7: the counter stays inside the current period
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < div_q);

  // R7: a write restarts the period from the new divisor
  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == div_q - 1'b1) && !tick);

endmodule

// File: rtl/line_param_reg.sv
module line_param_reg
  import lpr_pkg::*;
#(
  parameter int          NUM_LINES = 4,
  parameter int unsigned CLK_HZ    = 1843200
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [15:0]            wr_data,
  output logic [NUM_LINES-1:0]   rx_en,
  output logic [4*NUM_LINES-1:0] data_bits,
  output logic [NUM_LINES-1:0]   two_stop,
  output logic [NUM_LINES-1:0]   par_en,
  output logic [NUM_LINES-1:0]   par_odd,
  output logic [NUM_LINES-1:0]   bit_tick
);

  localparam int          LINE_W  = $clog2(NUM_LINES);
  localparam int unsigned MAX_DIV = (CLK_HZ + 25) / 50;
  localparam int          CNT_W   = $clog2(MAX_DIV + 1);

  logic [LINE_W-1:0] line_idx;
  line_cfg_t         cfg_new;
  logic [NUM_LINES-1:0] load;

  lpr_decode #(.LINE_W(LINE_W)) u_decode (
    .word     (wr_data),
    .line_idx (line_idx),
    .cfg      (cfg_new)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    line_cfg_t cfg_q;

    assign load[g] = wr_en && (line_idx == LINE_W'(g));

    lpr_line_store u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load[g]),
      .cfg_in (cfg_new),
      .cfg_q  (cfg_q)
    );

    lpr_tick_gen #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load[g]),
      .rate_code (cfg_new.rate),
      .tick      (bit_tick[g])
    );

    assign rx_en[g]          = cfg_q.rx_en;
    assign two_stop[g]       = cfg_q.two_stop;
    assign par_en[g]         = cfg_q.par_en;
    assign par_odd[g]        = cfg_q.par_odd;
    assign data_bits[4*g +: 4] = {2'b00, cfg_q.size} + 4'd5;
  end

  // R1: at most one line is written per cycle
  assert_one_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load));

endmodule

// File: tb/line_param_reg_tb.sv
module line_param_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL         = 4;
  localparam int CLK_HZ     = 96000;

  logic clk = 1'b0;
  logic rst_n, wr_en;
  logic [15:0] wr_data;
  logic [NL-1:0] rx_en, two_stop, par_en, par_odd, bit_tick;
  logic [4*NL-1:0] data_bits;

  line_param_reg #(.NUM_LINES(NL), .CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rx_en(rx_en), .data_bits(data_bits), .two_stop(two_stop),
    .par_en(par_en), .par_odd(par_odd), .bit_tick(bit_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int m_rx[NL], m_bits[NL], m_stop[NL], m_pen[NL], m_odd[NL];

  function automatic int exp_bps(input int code);
    case (code)
      0: return 50;     1: return 75;     2: return 110;   3: return 134;
      4: return 150;    5: return 300;    6: return 600;   7: return 1200;
      8: return 1800;   9: return 2000;   10: return 2400; 11: return 3600;
      12: return 4800;  13: return 7200;  default: return 9600;
    endcase
  endfunction

  function automatic int exp_div(input int code);
    int b;
    b = exp_bps(code);
    return (CLK_HZ + b / 2) / b;
  endfunction

  task automatic check_int(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_lines(input string req);
    for (int l = 0; l < NL; l++) begin
      check_int(req, $sformatf("rx_en[%0d]", l), int'(rx_en[l]), m_rx[l]);
      check_int(req, $sformatf("data_bits[%0d]", l), int'(data_bits[4*l +: 4]), m_bits[l]);
      check_int(req, $sformatf("two_stop[%0d]", l), int'(two_stop[l]), m_stop[l]);
      check_int(req, $sformatf("par_en[%0d]", l), int'(par_en[l]), m_pen[l]);
      check_int(req, $sformatf("par_odd[%0d]", l), int'(par_odd[l]), m_odd[l]);
    end
  endtask

  task automatic apply(input logic [15:0] w);
    int l;
    l = int'(w[1:0]);
    m_rx[l]   = int'(w[12]);
    m_bits[l] = int'(w[4:3]) + 5;
    m_stop[l] = int'(w[5]);
    m_pen[l]  = int'(w[6]);
    m_odd[l]  = int'(w[7]);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = 16'($urandom);
  endtask

  // Called right after apply: the first tick is due DIV-1 edges later
  task automatic measure(input int l, input int code, input string req, input bit first);
    int n, m;
    n = 0;
    while (!bit_tick[l] && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (first) check_int("R7", $sformatf("first tick delay line %0d code %0d", l, code), n, exp_div(code) - 1);
    @(negedge clk);
    m = 1;
    while (!bit_tick[l] && m < 5000) begin
      @(negedge clk);
      m++;
    end
    check_int(req, $sformatf("tick period line %0d code %0d", l, code), m, exp_div(code));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 16'h0;
    for (int l = 0; l < NL; l++) begin
      m_rx[l] = 0; m_bits[l] = 8; m_stop[l] = 0; m_pen[l] = 0; m_odd[l] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_lines("R8");
    measure(0, 14, "R8", 1'b0);

    // R9: line 1 with bit 2 and bits 15:13 set
    apply(16'b1110_0001_1010_1101);
    check_lines("R9");

    // R2: every size code on line 2
    for (int s = 0; s < 4; s++) begin
      apply(16'(2 | (s << 3)));
      check_lines("R2");
    end

    // R3: stop and parity combinations on line 3
    for (int c = 0; c < 8; c++) begin
      apply(16'(3 | (c << 5) | (3 << 3)));
      check_lines("R3");
    end

    // R5: enable then clear the receiver on line 0
    apply(16'h1000);
    check_lines("R5");
    apply(16'h0000);
    check_lines("R5");

    // R1: random words, one line at a time
    for (int i = 0; i < 30; i++) begin
      apply(16'($urandom));
      check_lines("R1");
    end

    // R1: junk on the bus without a strobe changes nothing
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      wr_data = 16'($urandom);
    end
    @(negedge clk);
    check_lines("R1");

    // R4 / R6 / R7: time every rate code
    for (int code = 0; code < 16; code++) begin
      apply(16'((code << 8) | (code % NL) | (1 << 12)));
      measure(code % NL, code, (code == 15) ? "R6" : "R4", 1'b1);
    end
    check_lines("R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule